// File: doc/BRIEF.md
# Byte Lane Swap Unit

This block reorders the byte lanes of a 32-bit data word on its way between a local bus and a PCI bus. The same rules serve read data and write data. A 2-bit mode selects one of four behaviours: pass-through, a halfword swap, a full byte reversal, or an automatic choice. In the automatic choice, the active-low byte enables of each access pick the swap. The active-low byte enables are moved with the same lane mapping as the data, so each enable stays with its byte.

The result is held in one registered pipeline stage with a valid/ready handshake. The stage stalls while the consumer holds ready low. A 2-bit indicator goes out with each word and reports which swap was actually applied. This lets a consumer or a checker confirm what the automatic mode decided.

Top module: `lane_swap_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Mode 00 passes data and byte enables through unchanged, and `out_kind` is 00.
- R3: Mode 01 swaps halfwords: output lane 3 = input lane 1, lane 2 = input lane 0, lane 1 = input lane 3, lane 0 = input lane 2. Lane n is bits 8n+7:8n. `out_kind` is 01.
- R4: Mode 10 reverses the byte order: output lane n = input lane 3-n. `out_kind` is 10.
- R5: In mode 11, `be_n` equal to 4'b1100 or 4'b0011 selects the halfword swap of R3, and `out_kind` is 01.
- R6: In mode 11, `be_n` with exactly one bit low (1110, 1101, 1011, 0111) selects the reversal of R4, and `out_kind` is 10.
- R7: In mode 11, every other `be_n` pattern passes the word unswapped, and `out_kind` is 00.
- R8: `out_be_n` bit n is the input `be_n` bit of the lane that fed output lane n.
- R9: `out_kind` never takes the value 11 while `out_valid` is high.
- R10: A word accepted (`in_valid` and `in_ready` high at a clock edge) appears on the outputs with `out_valid` high after exactly that edge.
- R11: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Stage can take a word |
| mode | input | 2 | Swap mode: 00 pass, 01 halfword, 10 reverse, 11 automatic |
| be_n | input | 4 | Active-low byte enables of the input word |
| in_data | input | 32 | Input data word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 32 | Reordered data word |
| out_be_n | output | 4 | Byte enables moved with the data |
| out_kind | output | 2 | Applied swap: 00 none, 01 halfword, 10 reversal |

## Verification
The bench builds the block with its default four lanes of eight bits. With only 16 byte-enable patterns, every pattern can be swept exhaustively in the automatic mode, and each fixed mode can be checked against explicit bit-slice mappings. Random back-to-back traffic exercises streaming at one word per cycle. A directed stall sequence holds a word while a different word waits at the input, then checks the release.

// File: rtl/lane_swap_pkg.sv
package lane_swap_pkg;
    typedef enum logic [1:0] {
        MODE_PASS = 2'b00,
        MODE_HALF = 2'b01,
        MODE_REV  = 2'b10,
        MODE_AUTO = 2'b11
    } swap_mode_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_HALF = 2'b01,
        KIND_REV  = 2'b10
    } swap_kind_e;
endpackage

// File: rtl/swap_kind_sel.sv
module swap_kind_sel
    import lane_swap_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [1:0]       mode,
    input  logic [LANES-1:0] be_n,
    output swap_kind_e       kind
);
    localparam int HALF = LANES / 2;
    localparam logic [LANES-1:0] LOW_HALF_ON  = {{HALF{1'b1}}, {HALF{1'b0}}};
    localparam logic [LANES-1:0] HIGH_HALF_ON = {{HALF{1'b0}}, {HALF{1'b1}}};

    logic half_pat;
    logic single_pat;

    always_comb begin
        half_pat   = (be_n == LOW_HALF_ON) || (be_n == HIGH_HALF_ON);
        single_pat = ($countones(be_n) == LANES - 1);
        unique case (swap_mode_e'(mode))
            MODE_PASS: kind = KIND_NONE;
            MODE_HALF: kind = KIND_HALF;
            MODE_REV:  kind = KIND_REV;
            default: begin
                if (half_pat)        kind = KIND_HALF;
                else if (single_pat) kind = KIND_REV;
                else                 kind = KIND_NONE;
            end
        endcase
    end
endmodule

// File: rtl/lane_permute.sv
module lane_permute
    import lane_swap_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  swap_kind_e                kind,
    input  logic [LANES*LANE_W-1:0]   din,
    output logic [LANES*LANE_W-1:0]   dout
);
    localparam int HALF = LANES / 2;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int SRC_HALF = (j + HALF) % LANES;
        localparam int SRC_REV  = LANES - 1 - j;
        always_comb begin
            unique case (kind)
                KIND_HALF: dout[j*LANE_W +: LANE_W] = din[SRC_HALF*LANE_W +: LANE_W];
                KIND_REV:  dout[j*LANE_W +: LANE_W] = din[SRC_REV*LANE_W +: LANE_W];
                default:   dout[j*LANE_W +: LANE_W] = din[j*LANE_W +: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/lane_swap_unit.sv
module lane_swap_unit
    import lane_swap_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [1:0]              mode,
    input  logic [LANES-1:0]        be_n,
    input  logic [LANES*LANE_W-1:0] in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*LANE_W-1:0] out_data,
    output logic [LANES-1:0]        out_be_n,
    output logic [1:0]              out_kind
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic             valid;
        logic [DW-1:0]    data;
        logic [LANES-1:0] be_n;
        swap_kind_e       kind;
    } stage_t;

    swap_kind_e       kind_sel;
    logic [DW-1:0]    data_sw;
    logic [LANES-1:0] be_sw;
    stage_t           st_d;
    stage_t           st_q;
    logic             take;

    swap_kind_sel #(.LANES(LANES)) sel_i (
        .mode (mode),
        .be_n (be_n),
        .kind (kind_sel)
    );

    lane_permute #(.LANES(LANES), .LANE_W(LANE_W)) data_perm_i (
        .kind (kind_sel),
        .din  (in_data),
        .dout (data_sw)
    );

    lane_permute #(.LANES(LANES), .LANE_W(1)) be_perm_i (
        .kind (kind_sel),
        .din  (be_n),
        .dout (be_sw)
    );

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.valid || out_ready;
        take     = in_valid && in_ready;
        if (take) begin
            st_d.valid = 1'b1;
            st_d.data  = data_sw;
            st_d.be_n  = be_sw;
            st_d.kind  = kind_sel;
        end else if (out_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, data: '0, be_n: '1, kind: KIND_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_be_n  = st_q.be_n;
    assign out_kind  = st_q.kind;
endmodule

// File: rtl/lane_swap_unit_chk.sv
module lane_swap_unit_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [1:0]              mode,
    input logic [LANES-1:0]        be_n,
    input logic [LANES*LANE_W-1:0] in_data,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*LANE_W-1:0] out_data,
    input logic [LANES-1:0]        out_be_n,
    input logic [1:0]              out_kind
);
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> out_valid); // R10
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |-> !in_ready); // R11
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be_n) && $stable(out_kind))); // R11
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_kind != 2'b11)); // R9
    AST_ENABLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> ($countones(out_be_n) == $countones($past(be_n)))); // R8
    AST_PASS_KIND: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && mode == 2'b00) |=> (out_kind == 2'b00 && out_data == $past(in_data))); // R2
    AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n) (!in_valid && out_ready) |=> !out_valid); // R10
endmodule

bind lane_swap_unit lane_swap_unit_chk #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .be_n(be_n), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_be_n(out_be_n),
    .out_kind(out_kind)
);

// File: tb/lane_swap_unit_tb_top.sv
module lane_swap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  mode = 2'b00;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_be_n;
    logic [1:0]  out_kind;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lane_swap_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .be_n(be_n), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_be_n(out_be_n),
        .out_kind(out_kind)
    );

    function automatic logic [1:0] exp_kind(logic [1:0] m, logic [3:0] b);
        if (m != 2'b11) return m;
        case (b)
            4'b1100, 4'b0011: return 2'b01;
            4'b1110, 4'b1101, 4'b1011, 4'b0111: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(logic [1:0] k, logic [31:0] d);
        case (k)
            2'b01: return {d[15:8], d[7:0], d[31:24], d[23:16]};
            2'b10: return {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: return d;
        endcase
    endfunction

    function automatic logic [3:0] exp_be(logic [1:0] k, logic [3:0] b);
        case (k)
            2'b01: return {b[1], b[0], b[3], b[2]};
            2'b10: return {b[0], b[1], b[2], b[3]};
            default: return b;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] m, logic [3:0] b);
        logic [1:0] k;
        k = exp_kind(m, b);
        if (m == 2'b00) return "R2";
        if (m == 2'b01) return "R3";
        if (m == 2'b10) return "R4";
        if (k == 2'b01) return "R5";
        if (k == 2'b10) return "R6";
        return "R7";
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_word(logic [1:0] m, logic [3:0] b, logic [31:0] d);
        logic [1:0] k;
        k = exp_kind(m, b);
        check(out_valid === 1'b1, "R10", {63'd0, out_valid}, 64'd1);
        check(out_data === exp_data(k, d), tag_of(m, b), {32'd0, out_data}, {32'd0, exp_data(k, d)});
        check(out_be_n === exp_be(k, b), "R8", {60'd0, out_be_n}, {60'd0, exp_be(k, b)});
        check(out_kind === k && out_kind != 2'b11, "R9", {62'd0, out_kind}, {62'd0, k});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0]  pm;
        logic [3:0]  pb;
        logic [31:0] pd;
        logic [31:0] a_data;
        bit          pend;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1", {63'd0, out_valid}, 64'd0);
        check(in_ready === 1'b1, "R1", {63'd0, in_ready}, 64'd1);
        rst_n = 1'b1;

        // Directed: every mode with every enable pattern, streamed back to back (R2-R8)
        pend = 0;
        pm = '0; pb = '0; pd = '0;
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 16; b++) begin
                @(negedge clk);
                if (pend) check_word(pm, pb, pd);
                pm = m[1:0]; pb = b[3:0]; pd = 32'hA1B2C3D4 ^ {8{b[3:0]}};
                in_valid = 1'b1; mode = pm; be_n = pb; in_data = pd;
                pend = 1;
            end
        end
        // Random stream
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (pend) check_word(pm, pb, pd);
            pm = 2'($urandom); pb = 4'($urandom); pd = $urandom;
            mode = pm; be_n = pb; in_data = pd; in_valid = 1'b1;
            pend = 1;
        end
        @(negedge clk);
        check_word(pm, pb, pd);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R10", {63'd0, out_valid}, 64'd0);

        // R11: stall holds word A while word B waits
        a_data = 32'h11223344;
        mode = 2'b11; be_n = 4'b0111; in_data = a_data; in_valid = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        check_word(2'b11, 4'b0111, a_data);
        check(in_ready === 1'b0, "R11", {63'd0, in_ready}, 64'd0);
        mode = 2'b01; be_n = 4'b0000; in_data = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        check(out_data === 32'h44332211, "R11", {32'd0, out_data}, 64'h44332211);
        check(out_kind === 2'b10 && out_be_n === 4'b1110, "R11", {58'd0, out_kind, out_be_n}, {58'd0, 2'b10, 4'b1110});
        check(in_ready === 1'b0, "R11", {63'd0, in_ready}, 64'd0);
        out_ready = 1'b1;
        @(negedge clk);
        check_word(2'b01, 4'b0000, 32'hDEADBEEF);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R10", {63'd0, out_valid}, 64'd0);

        // R1: reset mid-stream clears the stage
        in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule